// File: doc/BRIEF.md
# Dual-Issue Group Resource Tracker

This block sits beside an in-order scheduler that forms issue groups one candidate at a time. For each candidate it receives a class code with a valid strobe and answers in the same cycle whether that candidate may join the group being built. The answer depends on the group's current occupancy: two dedicated integer pipes, a flag recording that a generic integer operation has been placed, a count of integer operations, one memory port and one branch slot. The count is capped at two. Once a branch or a serializing operation has been placed, the group is closed.

An accepted request updates the occupancy at the next clock edge. A one-cycle new-cycle pulse starts an empty group. A request presented alongside that pulse is still judged against the group that is ending. Operations that use only one dedicated pipe must be placed before any generic integer operation in the same group. The scheduler maps its instructions onto the class codes: shifts go to pipe 0, flag-setting arithmetic to pipe 1, loads and stores to memory, and plain moves and other arithmetic to generic integer.

Top module: `issue_group_tracker`

## Requirements
- R1: Once synchronous reset `rst` has been released, the group is empty, `group_closed_o` is low and the count is zero, so a no-op request (class 0) is accepted.
- R2: A pipe-0 request (class 2) is accepted only when pipe 0 is free, no generic operation is in the group and the count is below 2. Acceptance marks pipe 0 busy and raises the count by one.
- R3: A pipe-1 request (class 3) is accepted only when pipe 1 is free, no generic operation is in the group and the count is below 2. Acceptance marks pipe 1 busy and raises the count by one.
- R4: A generic integer request (class 1) is accepted whenever the count is below 2. Acceptance sets the generic flag and raises the count by one.
- R5: A memory request (class 4) is accepted only while the memory port is free. Acceptance marks the port busy and leaves the integer count unchanged.
- R6: A branch request (class 5) is accepted while the branch slot is free, and its acceptance closes the group.
- R7: A serializing request (class 6) is accepted only when every resource is free and the count is zero, and its acceptance closes the group.
- R8: While the group is closed, every request is rejected, no-ops included, until a new-cycle pulse arrives.
- R9: In an open group a no-op (class 0) is always accepted and leaves the occupancy unchanged.
- R10: A new-cycle pulse empties the group at the next edge. A request in the same cycle is judged against the old group, and its effect is discarded.
- R11: Class code 7 is reserved and is always rejected.
- R12: `accept_o` is combinational from the current occupancy, the strobe and the class. The occupancy changes only on an edge where valid and accept are both high, or where a new-cycle pulse is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| new_cycle_i | input | 1 | Starts an empty group at the next edge |
| req_valid_i | input | 1 | A candidate is presented |
| req_class_i | input | 3 | Class code of the candidate |
| accept_o | output | 1 | The candidate may join the current group |
| group_closed_o | output | 1 | A branch or serializing operation has closed the group |

## Verification
Two functions can meet in one cycle: a new-cycle pulse, and a request that would close the group or raise the count. The bench provokes this by raising the pulse at random, and in directed steps, while a request is presented. It expects the answer to follow the old group and the next group to start empty. A bench reference model, built from the requirements, predicts every answer and the closed flag.

// File: rtl/igt_pkg.sv
package igt_pkg;
  typedef enum logic [2:0] {
    CLS_NOP   = 3'd0,
    CLS_GEN   = 3'd1,
    CLS_PIPE0 = 3'd2,
    CLS_PIPE1 = 3'd3,
    CLS_MEM   = 3'd4,
    CLS_BRANCH= 3'd5,
    CLS_SERIAL= 3'd6,
    CLS_RSVD  = 3'd7
  } igt_class_e;

  typedef struct packed {
    logic pipe0;
    logic pipe1;
    logic gen;
    logic mem;
    logic br;
    logic closed;
  } igt_flags_t;

  localparam igt_flags_t FLAGS_EMPTY = '{default: 1'b0};
endpackage

// File: rtl/igt_admit.sv
module igt_admit
  import igt_pkg::*;
#(
  parameter int INT_MAX = 2,
  parameter int CNT_W   = 2
) (
  input  igt_flags_t       cur_flags,
  input  logic [CNT_W-1:0] cur_cnt,
  input  logic [2:0]       cls,
  output logic             ok,
  output igt_flags_t       nxt_flags,
  output logic             cnt_inc
);
  logic room;
  logic all_free;

  assign room     = (cur_cnt < CNT_W'(INT_MAX));
  assign all_free = (cur_flags == FLAGS_EMPTY) && (cur_cnt == '0);

  always_comb begin
    ok        = 1'b0;
    nxt_flags = cur_flags;
    cnt_inc   = 1'b0;
    unique case (igt_class_e'(cls))
      CLS_NOP: ok = 1'b1;
      CLS_GEN: begin
        ok            = room;
        nxt_flags.gen = 1'b1;
        cnt_inc       = 1'b1;
      end
      CLS_PIPE0: begin
        ok              = room && !cur_flags.pipe0 && !cur_flags.gen;
        nxt_flags.pipe0 = 1'b1;
        cnt_inc         = 1'b1;
      end
      CLS_PIPE1: begin
        ok              = room && !cur_flags.pipe1 && !cur_flags.gen;
        nxt_flags.pipe1 = 1'b1;
        cnt_inc         = 1'b1;
      end
      CLS_MEM: begin
        ok            = !cur_flags.mem;
        nxt_flags.mem = 1'b1;
      end
      CLS_BRANCH: begin
        ok               = !cur_flags.br;
        nxt_flags.br     = 1'b1;
        nxt_flags.closed = 1'b1;
      end
      CLS_SERIAL: begin
        ok               = all_free;
        nxt_flags.closed = 1'b1;
      end
      default: ok = 1'b0;
    endcase
    if (cur_flags.closed) ok = 1'b0;
  end
endmodule

// File: rtl/igt_state.sv
module igt_state
  import igt_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             commit,
  input  igt_flags_t       nxt_flags,
  input  logic             cnt_inc,
  output igt_flags_t       flags_q,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      flags_q <= FLAGS_EMPTY;
      cnt_q   <= '0;
    end else if (commit) begin
      flags_q <= nxt_flags;
      if (cnt_inc) cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/issue_group_tracker.sv
module issue_group_tracker
  import igt_pkg::*;
#(
  parameter int INT_MAX = 2,
  localparam int CNT_W  = $clog2(INT_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       new_cycle_i,
  input  logic       req_valid_i,
  input  logic [2:0] req_class_i,
  output logic       accept_o,
  output logic       group_closed_o
);
  igt_flags_t       st_flags;
  logic [CNT_W-1:0] st_cnt;
  igt_flags_t       upd_flags;
  logic             upd_inc;
  logic             admit_ok;

  igt_admit #(.INT_MAX(INT_MAX), .CNT_W(CNT_W)) u_admit (
    .cur_flags (st_flags),
    .cur_cnt   (st_cnt),
    .cls       (req_class_i),
    .ok        (admit_ok),
    .nxt_flags (upd_flags),
    .cnt_inc   (upd_inc)
  );

  igt_state #(.CNT_W(CNT_W)) u_state (
    .clk       (clk),
    .rst       (rst),
    .clear     (new_cycle_i),
    .commit    (accept_o),
    .nxt_flags (upd_flags),
    .cnt_inc   (upd_inc),
    .flags_q   (st_flags),
    .cnt_q     (st_cnt)
  );

  assign accept_o       = req_valid_i && admit_ok;
  assign group_closed_o = st_flags.closed;
endmodule

// File: rtl/igt_checker.sv
module igt_checker
  import igt_pkg::*;
#(
  parameter int INT_MAX = 2,
  parameter int CNT_W   = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             new_cycle_i,
  input logic             req_valid_i,
  input logic [2:0]       req_class_i,
  input logic             accept_o,
  input logic             group_closed_o,
  input igt_flags_t       st_flags,
  input logic [CNT_W-1:0] st_cnt
);
  p_closed_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    group_closed_o |-> !accept_o);

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    st_cnt <= CNT_W'(INT_MAX));

  p_pipe0_after_gen_r2: assert property (@(posedge clk) disable iff (rst)
    (st_flags.gen && req_class_i == CLS_PIPE0) |-> !accept_o);

  p_pipe1_after_gen_r3: assert property (@(posedge clk) disable iff (rst)
    (st_flags.gen && req_class_i == CLS_PIPE1) |-> !accept_o);

  p_branch_closes_r6: assert property (@(posedge clk) disable iff (rst)
    (accept_o && req_class_i == CLS_BRANCH && !new_cycle_i) |=> group_closed_o);

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    new_cycle_i |=> (st_cnt == '0 && !group_closed_o));

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!accept_o && !new_cycle_i) |=> ($stable(st_cnt) && $stable(group_closed_o)));

  p_rsvd_r11: assert property (@(posedge clk) disable iff (rst)
    (req_class_i == CLS_RSVD) |-> !accept_o);
endmodule

bind issue_group_tracker igt_checker #(.INT_MAX(INT_MAX), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .new_cycle_i    (new_cycle_i),
  .req_valid_i    (req_valid_i),
  .req_class_i    (req_class_i),
  .accept_o       (accept_o),
  .group_closed_o (group_closed_o),
  .st_flags       (st_flags),
  .st_cnt         (st_cnt)
);

// File: tb/test_issue_group_tracker.sv
module test_issue_group_tracker;
  localparam logic [2:0] C_NOP = 3'd0, C_GEN = 3'd1, C_P0 = 3'd2, C_P1 = 3'd3,
                         C_MEM = 3'd4, C_BR = 3'd5, C_SER = 3'd6, C_RSV = 3'd7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic new_cycle = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_class = 3'd0;
  logic accept, closed;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic m_p0, m_p1, m_gen, m_mem, m_br, m_closed;
  int   m_cnt;

  always #2.5 clk = ~clk;

  issue_group_tracker i_issue_group_tracker (
    .clk(clk), .rst(rst), .new_cycle_i(new_cycle), .req_valid_i(req_valid),
    .req_class_i(req_class), .accept_o(accept), .group_closed_o(closed)
  );

  task automatic model_clear();
    m_p0 = 0; m_p1 = 0; m_gen = 0; m_mem = 0; m_br = 0; m_closed = 0; m_cnt = 0;
  endtask

  function automatic logic model_ok(input logic [2:0] c);
    if (m_closed) return 1'b0;
    case (c)
      C_NOP: return 1'b1;
      C_GEN: return m_cnt < 2;
      C_P0:  return !m_p0 && !m_gen && m_cnt < 2;
      C_P1:  return !m_p1 && !m_gen && m_cnt < 2;
      C_MEM: return !m_mem;
      C_BR:  return !m_br;
      C_SER: return !m_p0 && !m_p1 && !m_gen && !m_mem && !m_br && m_cnt == 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_apply(input logic [2:0] c);
    case (c)
      C_GEN: begin m_gen = 1; m_cnt++; end
      C_P0:  begin m_p0 = 1; m_cnt++; end
      C_P1:  begin m_p1 = 1; m_cnt++; end
      C_MEM: m_mem = 1;
      C_BR:  begin m_br = 1; m_closed = 1; end
      C_SER: m_closed = 1;
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] c, input logic nc, input string tag);
    logic exp;
    @(negedge clk);
    req_valid = v; req_class = c; new_cycle = nc;
    #1;
    exp = v && model_ok(c);
    check(tag, "accept", accept, exp);
    check(tag, "closed", closed, m_closed);
    @(posedge clk);
    if (nc) model_clear();
    else if (exp) model_apply(c);
  endtask

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      C_NOP: return "R9";  C_GEN: return "R4";  C_P0: return "R2";
      C_P1:  return "R3";  C_MEM: return "R5";  C_BR: return "R6";
      C_SER: return "R7";  default: return "R11";
    endcase
  endfunction

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    step(1, C_NOP, 0, "R1");
    // R2 R3 then generic refused at count 2 (R4), memory still fine (R5)
    step(1, C_P0, 0, "R2");
    step(1, C_P1, 0, "R3");
    step(1, C_GEN, 0, "R4");
    step(1, C_MEM, 0, "R5");
    step(1, C_MEM, 0, "R5");
    step(0, C_NOP, 1, "R10");
    // dedicated after generic refused
    step(1, C_GEN, 0, "R4");
    step(1, C_P0, 0, "R2");
    step(1, C_P1, 0, "R3");
    // R9: no-op does not consume count
    step(1, C_NOP, 0, "R9");
    step(1, C_GEN, 0, "R9");
    step(1, C_GEN, 0, "R4");
    step(1, C_RSV, 1, "R11");
    // R12: strobe low commits nothing
    step(0, C_GEN, 0, "R12");
    step(0, C_GEN, 0, "R12");
    step(1, C_GEN, 0, "R12");
    step(1, C_GEN, 0, "R12");
    step(1, C_GEN, 0, "R12");
    step(0, C_NOP, 1, "R10");
    // R6 branch closes, R8 everything refused
    step(1, C_MEM, 0, "R6");
    step(1, C_BR, 0, "R6");
    step(1, C_NOP, 0, "R8");
    step(1, C_BR, 1, "R8");
    // R10: branch presented with the pulse is judged, then discarded
    step(1, C_BR, 1, "R10");
    step(1, C_GEN, 0, "R10");
    step(0, C_NOP, 1, "R10");
    // R7 serializing
    step(1, C_SER, 0, "R7");
    step(1, C_GEN, 0, "R8");
    step(0, C_NOP, 1, "R7");
    step(1, C_MEM, 0, "R7");
    step(1, C_SER, 0, "R7");
    step(1, C_RSV, 1, "R11");

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] c;
      logic v, nc;
      c  = 3'($urandom_range(0, 7));
      v  = ($urandom_range(0, 7) != 0);
      nc = ($urandom_range(0, 5) == 0);
      step(v, c, nc, nc ? "R10" : tag_of(c));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule